// File: doc/BRIEF.md
# Zoned Sequential-Write Pointer Manager

This block keeps the bookkeeping for a small set of equal-size zones on a zoned block device. Each zone has a write pointer, a block offset inside the zone, and a fill state. Every command that arrives is checked against the addressed zone before it has any effect. A write must begin exactly at the zone's write pointer and must end at or before the zone's last block. A write that passes both checks moves the pointer forward. A zone that is full, or that holds data to be replaced, can only be rewritten after an explicit reset, which empties it.

Commands arrive on a valid/ready port. Each command carries an opcode, a zone index, a start offset inside the zone and a block count encoded as count minus one. One command can be taken per cycle. Each accepted command produces a one-cycle response on the next cycle. The response gives an accept flag, a reason code, a flag for reads that touch unwritten blocks, and the state and write pointer of the addressed zone after the command.

Top module: `zwp_manager`

## Requirements
- R1: While `rst` is high, and after it falls, every zone is empty with write pointer 0, `rsp_valid` is low, and `cmd_ready` is high whenever `rst` is low.
- R2: A command accepted at a clock edge (`cmd_valid` and `cmd_ready` high) gives `rsp_valid` high for exactly the following cycle. `rsp_valid` is low in every other cycle.
- R3: A write (op 2'b01) that starts at the zone's write pointer and ends at or before block 2^OFS_W is accepted with reason 0. It advances the pointer by the block count (`cmd_len_m1`+1).
- R4: A write to a zone that is not full, and whose start differs from the write pointer, is rejected with reason 3'd1 (unaligned). The zone is left unchanged.
- R5: A write that starts at the pointer but would end past block 2^OFS_W is rejected with reason 3'd2 (boundary) and leaves the zone unchanged. A write that ends exactly at 2^OFS_W is accepted and makes the zone full.
- R6: Any write to a full zone is rejected with reason 3'd3 (full), whatever its start. This check takes priority over the unaligned and boundary checks.
- R7: A read (op 2'b00) that stays inside the zone is accepted and never changes the zone. `rsp_unwritten` is 1 exactly when the read is accepted and covers a block at or above the write pointer.
- R8: A read whose last block would lie past the zone end is rejected with reason 3'd2 (boundary).
- R9: A reset (op 2'b10) is accepted in every state. It leaves the zone empty with write pointer 0.
- R10: Zone state is reported as 2'b00 empty (pointer 0), 2'b01 open (pointer strictly between 0 and 2^OFS_W), or 2'b10 full (pointer 2^OFS_W). `rsp_state` and `rsp_wp` show the addressed zone after the command.
- R11: Op 2'b11 is rejected with reason 3'd4 (bad opcode) and changes no zone.
- R12: A command changes no zone other than the one it addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 2 | 00 read, 01 write, 10 reset, 11 reserved |
| cmd_zone | input | ZONE_W | Zone index |
| cmd_start | input | OFS_W | First block offset inside the zone |
| cmd_len_m1 | input | OFS_W | Block count minus one |
| rsp_valid | output | 1 | Response present |
| rsp_ok | output | 1 | Command accepted |
| rsp_reason | output | 3 | 0 none, 1 unaligned, 2 boundary, 3 full, 4 bad opcode |
| rsp_unwritten | output | 1 | Accepted read covers unwritten blocks |
| rsp_state | output | 2 | Zone state after the command |
| rsp_wp | output | OFS_W+1 | Zone write pointer after the command |

## Verification
A command is driven on a falling edge and is taken at the next rising edge. Its response is registered at that same edge, so it is due one cycle after the stimulus. The bench reference model computes the expected response at the rising edge where the command is taken. The outputs are compared on the next falling edge, every cycle, including cycles where no response is expected. Commands follow one another with no gap, so a command to a zone written in the previous cycle must see the advanced pointer. Random commands aim at the current pointer half of the time, so accepted and rejected writes are both common.

// File: rtl/zwp_pkg.sv
package zwp_pkg;

  typedef int unsigned uint_t;

  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_RESET = 2'b10,
    OP_RSVD  = 2'b11
  } zwp_op_e;

  typedef enum logic [1:0] {
    ZS_EMPTY = 2'b00,
    ZS_OPEN  = 2'b01,
    ZS_FULL  = 2'b10
  } zwp_state_e;

  typedef enum logic [2:0] {
    RS_NONE      = 3'd0,
    RS_UNALIGNED = 3'd1,
    RS_BOUNDARY  = 3'd2,
    RS_FULL      = 3'd3,
    RS_BADOP     = 3'd4
  } zwp_reason_e;

  // One past the last block touched by a request
  function automatic uint_t span_end(uint_t start, uint_t len_m1);
    return start + len_m1 + 1;
  endfunction

  // Fill state implied by a write pointer value
  function automatic zwp_state_e state_for(uint_t wp, uint_t zone_blocks);
    if (wp == 0)           return ZS_EMPTY;
    if (wp == zone_blocks) return ZS_FULL;
    return ZS_OPEN;
  endfunction

endpackage

// File: rtl/zwp_check.sv
module zwp_check
  import zwp_pkg::*;
#(
  parameter int OFS_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid,
  input  logic [1:0]       op,
  input  logic [OFS_W-1:0] start,
  input  logic [OFS_W-1:0] len_m1,
  input  logic [1:0]       cur_state,
  input  logic [OFS_W:0]   cur_wp,
  output logic             ok,
  output logic [2:0]       reason,
  output logic             unwritten,
  output logic             upd,
  output logic             clr,
  output logic [1:0]       new_state,
  output logic [OFS_W:0]   new_wp
);
  localparam uint_t ZB = uint_t'(1) << OFS_W;

  uint_t end_u, wp_u, start_u;
  logic  upd_raw, clr_raw;

  always_comb begin
    start_u   = uint_t'(start);
    wp_u      = uint_t'(cur_wp);
    end_u     = span_end(start_u, uint_t'(len_m1));
    ok        = 1'b0;
    reason    = RS_NONE;
    unwritten = 1'b0;
    upd_raw   = 1'b0;
    clr_raw   = 1'b0;
    new_state = cur_state;
    new_wp    = cur_wp;
    case (zwp_op_e'(op))
      OP_READ: begin
        if (end_u > ZB) reason = RS_BOUNDARY;
        else begin
          ok        = 1'b1;
          unwritten = (end_u > wp_u);
        end
      end
      OP_WRITE: begin
        if (cur_state == ZS_FULL)  reason = RS_FULL;
        else if (start_u != wp_u)  reason = RS_UNALIGNED;
        else if (end_u > ZB)       reason = RS_BOUNDARY;
        else begin
          ok        = 1'b1;
          upd_raw   = 1'b1;
          new_wp    = (OFS_W+1)'(end_u);
          new_state = state_for(end_u, ZB);
        end
      end
      OP_RESET: begin
        ok        = 1'b1;
        upd_raw   = 1'b1;
        clr_raw   = 1'b1;
        new_state = ZS_EMPTY;
        new_wp    = '0;
      end
      default: reason = RS_BADOP;
    endcase
  end

  assign upd = valid & upd_raw;
  assign clr = valid & clr_raw;

  a_r6_full_rejects_write: assert property (@(posedge clk) disable iff (rst)
    (valid && op == OP_WRITE && cur_state == ZS_FULL) |-> (!ok && reason == RS_FULL && !upd));

  a_r4_unaligned_no_update: assert property (@(posedge clk) disable iff (rst)
    (valid && op == OP_WRITE && cur_state != ZS_FULL && {1'b0, start} != cur_wp)
      |-> (!upd && reason == RS_UNALIGNED));

  a_r7_read_never_updates: assert property (@(posedge clk) disable iff (rst)
    (valid && op == OP_READ) |-> !upd);

endmodule

// File: rtl/zwp_zone_table.sv
module zwp_zone_table
  import zwp_pkg::*;
#(
  parameter int ZONE_W = 2,
  parameter int OFS_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ZONE_W-1:0] sel,
  output logic [1:0]        rd_state,
  output logic [OFS_W:0]    rd_wp,
  input  logic              upd,
  input  logic              clr,
  input  logic [1:0]        wr_state,
  input  logic [OFS_W:0]    wr_wp
);
  localparam int NZ = 1 << ZONE_W;
  localparam logic [OFS_W:0] ZB = (OFS_W+1)'(1) << OFS_W;

  logic [1:0]     st_q [NZ];
  logic [OFS_W:0] wp_q [NZ];
  logic [NZ-1:0]  hit;

  for (genvar g = 0; g < NZ; g++) begin : g_zone
    assign hit[g] = upd && (sel == ZONE_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        st_q[g] <= ZS_EMPTY;
        wp_q[g] <= '0;
      end else if (hit[g]) begin
        st_q[g] <= wr_state;
        wp_q[g] <= wr_wp;
      end
    end

    a_r10_state_agrees_wp: assert property (@(posedge clk) disable iff (rst)
      ((st_q[g] == ZS_EMPTY) == (wp_q[g] == '0)) &&
      ((st_q[g] == ZS_FULL) == (wp_q[g] == ZB)) && (st_q[g] != 2'b11));

    a_r12_idle_zone_holds: assert property (@(posedge clk) disable iff (rst)
      !hit[g] |=> ($stable(wp_q[g]) && $stable(st_q[g])));

    a_r3_wp_only_grows: assert property (@(posedge clk) disable iff (rst)
      !(hit[g] && clr) |=> (wp_q[g] >= $past(wp_q[g])));
  end

  assign rd_state = st_q[sel];
  assign rd_wp    = wp_q[sel];

endmodule

// File: rtl/zwp_manager.sv
module zwp_manager
  import zwp_pkg::*;
#(
  parameter int ZONE_W = 2,
  parameter int OFS_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [ZONE_W-1:0] cmd_zone,
  input  logic [OFS_W-1:0]  cmd_start,
  input  logic [OFS_W-1:0]  cmd_len_m1,
  output logic              rsp_valid,
  output logic              rsp_ok,
  output logic [2:0]        rsp_reason,
  output logic              rsp_unwritten,
  output logic [1:0]        rsp_state,
  output logic [OFS_W:0]    rsp_wp
);
  logic           fire;
  logic [1:0]     cur_state, new_state;
  logic [OFS_W:0] cur_wp, new_wp;
  logic           dec_ok, dec_unw, dec_upd, dec_clr;
  logic [2:0]     dec_reason;

  assign cmd_ready = ~rst;
  assign fire      = cmd_valid & cmd_ready;

  zwp_zone_table #(.ZONE_W(ZONE_W), .OFS_W(OFS_W)) u_table (
    .clk(clk), .rst(rst), .sel(cmd_zone),
    .rd_state(cur_state), .rd_wp(cur_wp),
    .upd(dec_upd), .clr(dec_clr), .wr_state(new_state), .wr_wp(new_wp)
  );

  zwp_check #(.OFS_W(OFS_W)) u_check (
    .clk(clk), .rst(rst), .valid(fire), .op(cmd_op),
    .start(cmd_start), .len_m1(cmd_len_m1),
    .cur_state(cur_state), .cur_wp(cur_wp),
    .ok(dec_ok), .reason(dec_reason), .unwritten(dec_unw),
    .upd(dec_upd), .clr(dec_clr), .new_state(new_state), .new_wp(new_wp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid     <= 1'b0;
      rsp_ok        <= 1'b0;
      rsp_reason    <= RS_NONE;
      rsp_unwritten <= 1'b0;
      rsp_state     <= ZS_EMPTY;
      rsp_wp        <= '0;
    end else begin
      rsp_valid <= fire;
      if (fire) begin
        rsp_ok        <= dec_ok;
        rsp_reason    <= dec_reason;
        rsp_unwritten <= dec_unw;
        rsp_state     <= new_state;
        rsp_wp        <= new_wp;
      end
    end
  end

  a_r2_rsp_follows_fire: assert property (@(posedge clk) disable iff (rst)
    fire |=> rsp_valid);

  a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (rst)
    !fire |=> !rsp_valid);

  a_r9_reset_empties: assert property (@(posedge clk) disable iff (rst)
    (fire && cmd_op == OP_RESET) |=>
      (rsp_valid && rsp_ok && rsp_state == ZS_EMPTY && rsp_wp == '0));

  a_r11_badop_rejected: assert property (@(posedge clk) disable iff (rst)
    (fire && cmd_op == OP_RSVD) |=> (!rsp_ok && rsp_reason == RS_BADOP));

  a_r7_unwritten_only_ok: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_unwritten) |-> rsp_ok);

endmodule

// File: tb/zwp_manager_test.sv
`timescale 1ns/1ps
module zwp_manager_test;
  localparam int ZB = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [1:0] cmd_op = 2'b00;
  logic [1:0] cmd_zone = 2'b00;
  logic [3:0] cmd_start = 4'd0;
  logic [3:0] cmd_len_m1 = 4'd0;
  logic       rsp_valid, rsp_ok, rsp_unwritten;
  logic [2:0] rsp_reason;
  logic [1:0] rsp_state;
  logic [4:0] rsp_wp;

  int    n_chk = 0;
  int    n_bad = 0;
  string cur_tag = "R1";
  bit    done = 1'b0;

  // reference model state
  int    ref_wp [4];
  bit    exp_valid = 1'b0;
  int    exp_ok, exp_reason, exp_unw, exp_state, exp_wp;
  string exp_tag = "R2";

  always #2 clk = ~clk;

  zwp_manager #(.ZONE_W(2), .OFS_W(4)) uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_zone(cmd_zone), .cmd_start(cmd_start),
    .cmd_len_m1(cmd_len_m1), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
    .rsp_reason(rsp_reason), .rsp_unwritten(rsp_unwritten),
    .rsp_state(rsp_state), .rsp_wp(rsp_wp)
  );

  function automatic int st_of(int wp);
    // R10 encoding: 0 empty, 1 open, 2 full
    if (wp == 0) return 0;
    if (wp >= ZB) return 2;
    return 1;
  endfunction

  // behavioural model, evaluated at the edge that takes the command
  always @(posedge clk) begin
    if (rst) begin
      exp_valid = 1'b0;
      foreach (ref_wp[k]) ref_wp[k] = 0;
    end else if (cmd_valid && cmd_ready) begin
      int z, s, e;
      z = int'(cmd_zone);
      s = int'(cmd_start);
      e = s + int'(cmd_len_m1) + 1;
      exp_valid = 1'b1; exp_tag = cur_tag;
      exp_ok = 0; exp_reason = 0; exp_unw = 0;
      if (cmd_op == 2'b00) begin
        if (e > ZB) exp_reason = 2;
        else begin exp_ok = 1; exp_unw = (e > ref_wp[z]) ? 1 : 0; end
      end else if (cmd_op == 2'b01) begin
        if (ref_wp[z] == ZB) exp_reason = 3;
        else if (s != ref_wp[z]) exp_reason = 1;
        else if (e > ZB) exp_reason = 2;
        else begin exp_ok = 1; ref_wp[z] = e; end
      end else if (cmd_op == 2'b10) begin
        exp_ok = 1; ref_wp[z] = 0;
      end else exp_reason = 4;
      exp_wp = ref_wp[z];
      exp_state = st_of(ref_wp[z]);
    end else exp_valid = 1'b0;
  end

  // compare every cycle, away from the rising edge
  always @(negedge clk) begin
    if (!rst && !done && (exp_valid || rsp_valid)) begin
      n_chk++;
      if (rsp_valid !== exp_valid ||
          (exp_valid && (int'(rsp_ok) != exp_ok || int'(rsp_reason) != exp_reason ||
                         int'(rsp_unwritten) != exp_unw || int'(rsp_state) != exp_state ||
                         int'(rsp_wp) != exp_wp))) begin
        n_bad++;
        $display("FAIL %s: got v=%0d ok=%0d rs=%0d unw=%0d st=%0d wp=%0d exp v=%0d ok=%0d rs=%0d unw=%0d st=%0d wp=%0d",
                 exp_tag, rsp_valid, rsp_ok, rsp_reason, rsp_unwritten, rsp_state, rsp_wp,
                 exp_valid, exp_ok, exp_reason, exp_unw, exp_state, exp_wp);
      end
    end
  end

  task automatic chk(bit cond, string tag, int act, int exp);
    n_chk++;
    if (!cond) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(int op, int z, int s, int l, string tag);
    cmd_valid  = 1'b1;
    cmd_op     = 2'(op);
    cmd_zone   = 2'(z);
    cmd_start  = 4'(s);
    cmd_len_m1 = 4'(l);
    cur_tag    = tag;
  endtask

  task automatic issue(int op, int z, int s, int l, string tag);
    @(negedge clk);
    drive(op, z, s, l, tag);
  endtask

  task automatic idle();
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R2: watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cmd_ready == 1'b0, "R1", int'(cmd_ready), 0);
    chk(rsp_valid == 1'b0, "R1", int'(rsp_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R1", int'(cmd_ready), 1);
    chk(rsp_valid == 1'b0, "R1", int'(rsp_valid), 0);
    // every zone reads back empty after reset
    for (int z = 0; z < 4; z++) issue(0, z, 0, 0, "R1");
    idle();
    // sequential fill of zone 0, back to back
    issue(1, 0, 0, 3, "R3");       // wp 0 -> 4, open
    issue(1, 0, 2, 0, "R4");       // start behind wp
    issue(1, 0, 9, 1, "R4");       // start ahead of wp
    issue(1, 0, 4, 12, "R5");      // end 17 > 16
    issue(1, 0, 4, 11, "R5");      // end exactly 16 -> full
    issue(1, 0, 0, 0, "R6");       // full, start 0
    issue(1, 0, 15, 0, "R6");      // full, any start
    issue(0, 0, 0, 15, "R7");      // whole zone, all written
    // zone 1 partial, reads around the pointer
    issue(0, 1, 0, 0, "R7");       // empty zone, unwritten
    issue(1, 1, 0, 7, "R3");       // wp 8
    issue(0, 1, 5, 1, "R7");       // blocks 5..6 written
    issue(0, 1, 6, 1, "R7");       // blocks 6..7 written
    issue(0, 1, 7, 1, "R7");       // block 8 unwritten
    issue(0, 1, 10, 9, "R8");      // ends past zone
    issue(0, 1, 15, 1, "R8");      // one block past end
    issue(3, 1, 8, 0, "R11");      // reserved opcode
    issue(0, 1, 0, 0, "R11");      // zone 1 unchanged
    // independence of zones
    issue(1, 2, 0, 1, "R12");
    issue(0, 3, 0, 0, "R12");      // zone 3 still empty
    issue(0, 1, 0, 0, "R12");      // zone 1 still at 8
    // reset in every state
    issue(2, 0, 5, 3, "R9");       // full -> empty
    issue(2, 1, 0, 0, "R9");       // open -> empty
    issue(2, 3, 0, 0, "R9");       // empty -> empty
    issue(1, 0, 0, 15, "R9");      // rewrite after reset, single full write
    issue(0, 2, 0, 0, "R12");      // zone 2 kept wp 2
    idle();
    idle();
    // mixed random traffic
    for (int i = 0; i < 600; i++) begin
      int z, r, op, s, l;
      @(negedge clk);
      z  = int'($urandom_range(0, 3));
      r  = int'($urandom_range(0, 9));
      op = (r < 5) ? 1 : (r < 8) ? 0 : (r < 9) ? 2 : 3;
      if ($urandom_range(0, 1) == 1 && ref_wp[z] < ZB) s = ref_wp[z];
      else s = int'($urandom_range(0, 15));
      l  = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 15)) : int'($urandom_range(0, 4));
      drive(op, z, s, l, (op == 1) ? "R5" : (op == 0) ? "R7" : (op == 2) ? "R9" : "R11");
      if ($urandom_range(0, 7) == 0) idle();
    end
    idle();
    idle();
    finish_run();
  end

endmodule